// File: doc/BRIEF.md
# Two-Wire Bus Ownership Handshake Controller

This block lets a local bus master share one external bus with a single peer that has higher priority, with no arbiter between them. The peer drives an active-low grant line: high means the peer wants the bus, low means the bus is free. The block samples this line through a synchroniser. When local logic has a request pending and the grant is low, the block drives its active-low bus-driven output low. This output feeds the peer's hold-acknowledge, so the same edge both claims the bus and tells the peer that the bus is busy.

Local logic asks for either a single access or a line burst through a valid/ack request port. The block then starts the cycle with a one-clock transfer-start strobe. It holds an active-low chip-select until the last transfer acknowledge arrives, and it signals completion with a done pulse. A burst is one indivisible ownership period: a grant withdrawn partway through a cycle is honoured only after the final acknowledge. If the grant is still low and another request is waiting, the next cycle follows with no gap and the bus stays owned.

Top module: `busown_ctrl`

## Requirements
- R1: While reset is active and right after it, bus_drv_n, ts_n and cs_n are high (released, inactive), and req_ack and req_done are low.
- R2: The grant input passes through SYNC_STAGES flip-flops, which reset to the not-granted level. req_ack is high in the same cycle as req_valid only when the synchronised grant is low and the block is idle or completing its final beat. A falling grant_n_in therefore enables acceptance only after SYNC_STAGES rising edges.
- R3: On the clock edge that accepts a request, bus_drv_n, ts_n and cs_n all go low together.
- R4: ts_n is low for exactly one clock per bus cycle. It is not repeated for later beats of a burst.
- R5: A request with req_burst=0 completes after SINGLE_BEATS edges with ta_n low. A request with req_burst=1 completes after BURST_BEATS such edges. cs_n stays low until the edge that samples the final acknowledge.
- R6: Once a cycle has started, bus_drv_n stays low until its final acknowledge, even if grant_n_in goes high during the cycle.
- R7: req_done is high in exactly the cycle in which the final acknowledge (ta_n low) is present. It is low on earlier beats.
- R8: On the edge after the final acknowledge, bus_drv_n and cs_n return high, unless the synchronised grant is low and req_valid is high. In that case bus_drv_n stays low and a new cycle starts with ts_n low.
- R9: While the synchronised grant is high, no request is accepted and bus_drv_n stays high when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_n_in | input | 1 | Active-low grant from the peer (high = peer wants the bus) |
| req_valid | input | 1 | Local request pending |
| req_burst | input | 1 | 1 = line burst, 0 = single access; sampled on acceptance |
| req_ack | output | 1 | Request accepted this cycle |
| req_done | output | 1 | Final acknowledge of the current cycle present this cycle |
| ta_n | input | 1 | Active-low transfer acknowledge, one per beat |
| bus_drv_n | output | 1 | Active-low bus-driven / ownership indication to the peer |
| ts_n | output | 1 | Active-low transfer-start strobe |
| cs_n | output | 1 | Active-low chip-select / byte-enable gate for the cycle |

## Verification
The bench builds the block with its defaults: SYNC_STAGES=2, SINGLE_BEATS=1 and BURST_BEATS=4. With two synchroniser stages, the two-edge delay between a grant change and its effect can be observed directly. A grant withdrawn two cycles before the first beat is seen by the controller while the cycle is still in progress, which tests that ownership is held through a four-beat burst. The four-beat burst also separates final from non-final acknowledges for the done pulse and the single transfer-start strobe. Back-to-back follow-on requests are tested both with the grant held low and with the grant withdrawn.

// File: rtl/busown_pkg.sv
package busown_pkg;

   typedef enum logic {
      OWN_IDLE = 1'b0,
      OWN_XFER = 1'b1
   } own_state_e;

   function automatic int unsigned beats_width(input int unsigned max_beats);
      return (max_beats > 1) ? $clog2(max_beats) : 1;
   endfunction

endpackage

// File: rtl/busown_grant_sync.sv
module busown_grant_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= {STAGES{RESET_VAL}};
            end else if (STAGES == 1) begin
               chain_q[0] <= d_in;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], d_in};
            end
         end
         assign q_out = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/busown_beat_cnt.sv
module busown_beat_cnt #(
   parameter int unsigned SINGLE_BEATS = 1,
   parameter int unsigned BURST_BEATS  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic load_burst,
   input  logic beat,
   output logic last
);

   localparam int unsigned MaxBeats = (BURST_BEATS > SINGLE_BEATS) ? BURST_BEATS : SINGLE_BEATS;
   localparam int unsigned CntW     = busown_pkg::beats_width(MaxBeats);
   localparam logic [CntW-1:0] SingleInit = CntW'(SINGLE_BEATS - 1);
   localparam logic [CntW-1:0] BurstInit  = CntW'(BURST_BEATS - 1);

   logic [CntW-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load) begin
         remain_q <= load_burst ? BurstInit : SingleInit;
      end else if (beat && (remain_q != '0)) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign last = (remain_q == '0);

endmodule

// File: rtl/busown_ctrl.sv
module busown_ctrl #(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned SINGLE_BEATS = 1,
   parameter int unsigned BURST_BEATS  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_n_in,
   input  logic req_valid,
   input  logic req_burst,
   output logic req_ack,
   output logic req_done,
   input  logic ta_n,
   output logic bus_drv_n,
   output logic ts_n,
   output logic cs_n
);
   import busown_pkg::*;

   generate
      if (SINGLE_BEATS < 1) begin : g_bad_single
         $error("busown_ctrl: SINGLE_BEATS must be at least 1");
      end
      if (BURST_BEATS < 1) begin : g_bad_burst
         $error("busown_ctrl: BURST_BEATS must be at least 1");
      end
      if (SYNC_STAGES > 8) begin : g_bad_sync
         $error("busown_ctrl: SYNC_STAGES above 8 is not supported");
      end
   endgenerate

   own_state_e state_q;
   logic       grant_n_s;
   logic       grant_ok;
   logic       beat_last;
   logic       in_xfer;
   logic       beat_seen;
   logic       final_beat;
   logic       accept;

   busown_grant_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) i_grant_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (grant_n_in),
      .q_out (grant_n_s)
   );

   assign grant_ok   = ~grant_n_s;
   assign in_xfer    = (state_q == OWN_XFER);
   assign beat_seen  = in_xfer & ~ta_n;
   assign final_beat = beat_seen & beat_last;
   assign accept     = req_valid & grant_ok & (~in_xfer | final_beat);

   busown_beat_cnt #(
      .SINGLE_BEATS (SINGLE_BEATS),
      .BURST_BEATS  (BURST_BEATS)
   ) i_beat_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .load_burst (req_burst),
      .beat       (beat_seen),
      .last       (beat_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= OWN_IDLE;
         bus_drv_n <= 1'b1;
         ts_n      <= 1'b1;
         cs_n      <= 1'b1;
      end else begin
         ts_n <= ~accept;
         if (accept) begin
            state_q   <= OWN_XFER;
            bus_drv_n <= 1'b0;
            cs_n      <= 1'b0;
         end else if (final_beat) begin
            state_q   <= OWN_IDLE;
            bus_drv_n <= 1'b1;
            cs_n      <= 1'b1;
         end
      end
   end

   assign req_ack  = accept;
   assign req_done = final_beat;

endmodule

// File: rtl/busown_ctrl_chk.sv
module busown_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ack,
   input logic req_done,
   input logic ta_n,
   input logic bus_drv_n,
   input logic ts_n,
   input logic cs_n
);

   p_accept_owns_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> (!ts_n && !bus_drv_n && !cs_n));

   p_ts_in_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ts_n |-> (!bus_drv_n && !cs_n));

   p_ts_one_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ts_n && !req_ack) |=> ts_n);

   p_hold_in_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !req_done) |=> !bus_drv_n);

   p_done_on_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> (!ta_n && !cs_n));

   p_release_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_done && !req_ack) |=> (bus_drv_n && cs_n && ts_n));

   p_ack_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> req_valid);

   p_ack_only_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> (bus_drv_n || req_done));

endmodule

bind busown_ctrl busown_ctrl_chk i_busown_ctrl_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ack   (req_ack),
   .req_done  (req_done),
   .ta_n      (ta_n),
   .bus_drv_n (bus_drv_n),
   .ts_n      (ts_n),
   .cs_n      (cs_n)
);

// File: tb/test_busown_ctrl.sv
module test_busown_ctrl;

   localparam int unsigned SyncStages  = 2;
   localparam int unsigned SingleBeats = 1;
   localparam int unsigned BurstBeats  = 4;

   typedef struct packed {
      logic burst;
      logic revoke;
      logic follow;
      logic exp_keep;
   } vec_t;

   localparam int NumVec = 7;
   localparam vec_t Vecs [NumVec] = '{
      '{burst:1'b0, revoke:1'b0, follow:1'b0, exp_keep:1'b0},
      '{burst:1'b1, revoke:1'b0, follow:1'b0, exp_keep:1'b0},
      '{burst:1'b0, revoke:1'b1, follow:1'b0, exp_keep:1'b0},
      '{burst:1'b1, revoke:1'b1, follow:1'b0, exp_keep:1'b0},
      '{burst:1'b0, revoke:1'b0, follow:1'b1, exp_keep:1'b1},
      '{burst:1'b1, revoke:1'b0, follow:1'b1, exp_keep:1'b1},
      '{burst:1'b1, revoke:1'b1, follow:1'b1, exp_keep:1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic grant_n_in = 1'b0;
   logic req_valid = 1'b0;
   logic req_burst = 1'b0;
   logic ta_n = 1'b1;
   logic req_ack, req_done, bus_drv_n, ts_n, cs_n;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   busown_ctrl #(
      .SYNC_STAGES  (SyncStages),
      .SINGLE_BEATS (SingleBeats),
      .BURST_BEATS  (BurstBeats)
   ) i_busown_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .grant_n_in (grant_n_in),
      .req_valid  (req_valid),
      .req_burst  (req_burst),
      .req_ack    (req_ack),
      .req_done   (req_done),
      .ta_n       (ta_n),
      .bus_drv_n  (bus_drv_n),
      .ts_n       (ts_n),
      .cs_n       (cs_n)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      step();
      step();
      check("R1 bus_drv_n in reset", bus_drv_n, 1'b1);
      check("R1 ts_n in reset", ts_n, 1'b1);
      check("R1 cs_n in reset", cs_n, 1'b1);
      check("R1 req_ack in reset", req_ack, 1'b0);
      check("R1 req_done in reset", req_done, 1'b0);
      rst_n = 1'b1;
      step();
      check("R1 bus_drv_n after reset", bus_drv_n, 1'b1);
      step();
      step();

      // table walk
      for (int v = 0; v < NumVec; v++) begin
         int nbeats;
         nbeats = Vecs[v].burst ? BurstBeats : SingleBeats;
         step();
         req_valid = 1'b1;
         req_burst = Vecs[v].burst;
         #1;
         check("R2 req_ack on grant", req_ack, 1'b1);
         step();
         req_valid = 1'b0;
         req_burst = 1'b0;
         check("R3 bus_drv_n on accept", bus_drv_n, 1'b0);
         check("R3 ts_n on accept", ts_n, 1'b0);
         check("R3 cs_n on accept", cs_n, 1'b0);
         if (Vecs[v].revoke) grant_n_in = 1'b1;
         for (int w = 0; w < 2; w++) begin
            step();
            check("R4 ts_n single clock", ts_n, 1'b1);
            check("R6 bus held during cycle", bus_drv_n, 1'b0);
         end
         for (int b = 0; b < nbeats; b++) begin
            step();
            ta_n = 1'b0;
            if (b == nbeats - 1) req_valid = Vecs[v].follow;
            #1;
            check("R7 req_done on beat", req_done, (b == nbeats - 1));
            check("R5 cs_n low through beats", cs_n, 1'b0);
            check("R4 ts_n not repeated", ts_n, 1'b1);
            check("R6 bus held on beat", bus_drv_n, 1'b0);
         end
         step();
         ta_n = 1'b1;
         if (Vecs[v].exp_keep) begin
            check("R8 back-to-back keeps bus", bus_drv_n, 1'b0);
            check("R8 back-to-back ts_n", ts_n, 1'b0);
         end else begin
            check("R8 release bus_drv_n", bus_drv_n, 1'b1);
            check("R5 release cs_n", cs_n, 1'b1);
         end
         req_valid = 1'b0;
         grant_n_in = 1'b0;
         if (Vecs[v].exp_keep) begin
            ta_n = 1'b0;
            #1;
            check("R7 follow-on done", req_done, 1'b1);
            step();
            ta_n = 1'b1;
            check("R8 follow-on release", bus_drv_n, 1'b1);
         end
         step();
         step();
         step();
      end

      // R9 and R2: grant held high, then synchroniser latency
      step();
      grant_n_in = 1'b1;
      step();
      step();
      step();
      req_valid = 1'b1;
      for (int i = 0; i < 4; i++) begin
         #1;
         check("R9 no accept while peer holds", req_ack, 1'b0);
         check("R9 bus stays released", bus_drv_n, 1'b1);
         step();
      end
      grant_n_in = 1'b0;
      #1;
      check("R2 sync latency edge0", req_ack, 1'b0);
      step();
      check("R2 sync latency edge1", req_ack, 1'b0);
      step();
      check("R2 accept after sync", req_ack, 1'b1);
      step();
      req_valid = 1'b0;
      check("R3 bus_drv_n after sync accept", bus_drv_n, 1'b0);
      ta_n = 1'b0;
      #1;
      check("R5 single completes on first ack", req_done, 1'b1);
      step();
      ta_n = 1'b1;
      check("R8 release after single", bus_drv_n, 1'b1);
      step();
      finish_run();
   end

endmodule